// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

The block serves sixteen general-purpose pins in two banks of eight. Software reaches it through a synchronous byte bus. Each pin has two registers:

- **Drive register.** Sets the pin's output level, its direction and whether it drives push-pull or open-drain. It also keeps the pull-resistor settings, which are stored only.
- **Sense register.** Returns the synchronized pin level and holds a two-bit edge-sensitivity field.

Every selected edge on a pin sets that pin's bit in its bank's event register, whether or not the pin is masked. Writing ones to an event register clears those bits, so writing back the value just read acknowledges exactly the events that were seen. A per-bank mask register hides chosen pins from the single interrupt request output.

A host reads the event registers when the request rises, writes the same values back, and serves each pin it found set. Reads return data in the same cycle as the address. Writes take effect at the clock edge on which `bus_we` is high.

Top module: `edge_gpio_ctrl`

## Requirements
- R1: After reset:
  - every drive register, sense edge field, event register and mask register reads zero;
  - `pin_oe` and `pin_out` are all zero;
  - `irq` is low.
- R2: The drive register of pin n sits at 0x2B+n for pins 0–7 and at 0x3B+(n−8) for pins 8–15. It stores write-data bits 5:0 and reads them back, with bits 7:6 reading zero. Its fields are:
  - bit 5: direction, 1 = output;
  - bit 4: open-drain;
  - bit 3: pull enable;
  - bits 2:1: pull select;
  - bit 0: output level.
- R3: `pin_out[n]` equals drive bit 0. With drive bit 4 clear, `pin_oe[n]` equals drive bit 5.
- R4: With drive bits 5 and 4 both set, `pin_oe[n]` is the inverse of drive bit 0. With drive bit 5 clear, `pin_oe[n]` is 0 whatever bit 4 is.
- R5: The sense register of pin n sits at 0x33+n for pins 0–7 and at 0x43+(n−8) for pins 8–15.
  - Bit 0 returns `pin_in[n]` through a two-flop synchronizer. A change before clock edge k is visible after edge k+1 and not after edge k.
  - Bits 2:1 hold the stored edge mode.
  - Bits 7:3 read zero.
- R6: The edge mode selects which edges set the pin's event bit: 0 = none, 1 = falling, 2 = rising, 3 = both. The event bit is set by the third clock edge after the input changes.
- R7: The event registers are 0x0B for bank 0 and 0x0C for bank 1, with bit i belonging to pin 8·bank+i. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R8: An edge detected in the same cycle as a clearing write to its bit leaves the bit set.
- R9: The mask registers are 0x19 for bank 0 and 0x1A for bank 1, read back as written, with bit i masking pin 8·bank+i. Event bits are set whether or not the pin is masked.
- R10: `irq` is high exactly when some event bit is set and its mask bit is clear.
- R11: Reads of unmapped addresses return zero. Writes to sense bit 0 do not change the returned level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output levels to the pads |
| pin_oe | output | 16 | Output enables to the pads |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check these rules on every cycle:
- an event bit only rises after a detected edge;
- event bits hold when nothing touches them;
- a clearing write empties its bits unless an edge competes, and a competing edge keeps its bit set;
- writing an input direction, or open-drain with level high, turns the pad driver off by the next cycle.

Only the bench scenarios can show the rest:
- the register address map;
- the mapping of edge modes to falling, rising and both edges;
- the two-cycle synchronizer latency of the level readback;
- mask gating of the request;
- zero reads of unmapped addresses.

// File: rtl/edge_gpio_pkg.sv
package edge_gpio_pkg;

  localparam int BANK_PINS = 8;
  localparam int BANK_STRIDE = 16;

  localparam logic [7:0] DRV_BASE  = 8'h2B;
  localparam logic [7:0] SNS_BASE  = 8'h33;
  localparam logic [7:0] EVT_BASE  = 8'h0B;
  localparam logic [7:0] MSK_BASE  = 8'h19;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  typedef struct packed {
    logic       dir;
    logic       odrain;
    logic       pull_en;
    logic [1:0] pull_sel;
    logic       level;
  } drv_ctl_t;

  function automatic logic [7:0] drv_addr(input int p);
    return DRV_BASE + 8'((p / BANK_PINS) * BANK_STRIDE + (p % BANK_PINS));
  endfunction

  function automatic logic [7:0] sns_addr(input int p);
    return SNS_BASE + 8'((p / BANK_PINS) * BANK_STRIDE + (p % BANK_PINS));
  endfunction

endpackage

// File: rtl/edge_gpio_sync.sv
module edge_gpio_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] level_prev
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level      = sync_q;
  assign level_prev = prev_q;

endmodule

// File: rtl/edge_gpio_pin.sv
module edge_gpio_pin
  import edge_gpio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       drv_we,
  input  logic       sns_we,
  input  logic [7:0] wdata,
  input  logic       lvl,
  input  logic       lvl_prev,
  output drv_ctl_t   drv_q,
  output logic [1:0] mode_q,
  output logic       edge_hit,
  output logic       pin_out,
  output logic       pin_oe
);

  drv_ctl_t   drv_d;
  edge_mode_e mode_d;
  logic       rise;
  logic       fall;

  always_comb begin
    drv_d  = drv_ctl_t'(wdata[5:0]);
    mode_d = edge_mode_e'(wdata[2:1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q  <= '0;
      mode_q <= EDGE_OFF;
    end else begin
      if (drv_we) drv_q  <= drv_d;
      if (sns_we) mode_q <= mode_d;
    end
  end

  always_comb begin
    rise = lvl & ~lvl_prev;
    fall = ~lvl & lvl_prev;
    unique case (edge_mode_e'(mode_q))
      EDGE_FALL: edge_hit = fall;
      EDGE_RISE: edge_hit = rise;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  end

  assign pin_out = drv_q.level;
  assign pin_oe  = drv_q.dir & ~(drv_q.odrain & drv_q.level);

  // R4
  dir_in_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_we && !wdata[5]) |=> !pin_oe);

  // R4
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_we && wdata[5] && wdata[4] && wdata[0]) |=> (!pin_oe && pin_out));

endmodule

// File: rtl/edge_gpio_bank.sv
module edge_gpio_bank #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] edge_hit,
  input  logic            evt_we,
  input  logic            msk_we,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] evt_q,
  output logic [PINS-1:0] msk_q,
  output logic            req
);

  logic [PINS-1:0] clr_bits;
  logic [PINS-1:0] evt_d;

  always_comb begin
    clr_bits = evt_we ? wdata : '0;
    evt_d    = (evt_q & ~clr_bits) | edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      msk_q <= '0;
    end else begin
      evt_q <= evt_d;
      if (msk_we) msk_q <= wdata;
    end
  end

  assign req = |(evt_q & ~msk_q);

  // R6
  evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit == '0) |=> ((evt_q & ~$past(evt_q)) == '0));

  // R7
  evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_we |=> ((evt_q & $past(wdata & ~edge_hit)) == '0));

  // R8
  evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((evt_q & $past(edge_hit)) == $past(edge_hit)));

  // R7
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_we && edge_hit == '0) |=> $stable(evt_q));

endmodule

// File: rtl/edge_gpio_ctrl.sv
module edge_gpio_ctrl
  import edge_gpio_pkg::*;
#(
  parameter  int NUM_BANKS = 2,
  localparam int PINS      = NUM_BANKS * BANK_PINS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      bus_addr,
  input  logic            bus_we,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic            irq
);

  logic [PINS-1:0]      lvl;
  logic [PINS-1:0]      lvl_prev;
  logic [PINS-1:0]      edge_hit;
  drv_ctl_t             drv_q  [PINS];
  logic [1:0]           mode_q [PINS];
  logic [BANK_PINS-1:0] evt_q  [NUM_BANKS];
  logic [BANK_PINS-1:0] msk_q  [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_req;

  edge_gpio_sync #(.WIDTH(PINS)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (pin_in),
    .level      (lvl),
    .level_prev (lvl_prev)
  );

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    localparam logic [7:0] A_DRV = drv_addr(p);
    localparam logic [7:0] A_SNS = sns_addr(p);

    edge_gpio_pin u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .drv_we   (bus_we && bus_addr == A_DRV),
      .sns_we   (bus_we && bus_addr == A_SNS),
      .wdata    (bus_wdata),
      .lvl      (lvl[p]),
      .lvl_prev (lvl_prev[p]),
      .drv_q    (drv_q[p]),
      .mode_q   (mode_q[p]),
      .edge_hit (edge_hit[p]),
      .pin_out  (pin_out[p]),
      .pin_oe   (pin_oe[p])
    );
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [7:0] A_EVT = EVT_BASE + 8'(b);
    localparam logic [7:0] A_MSK = MSK_BASE + 8'(b);

    edge_gpio_bank #(.PINS(BANK_PINS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_hit (edge_hit[b*BANK_PINS +: BANK_PINS]),
      .evt_we   (bus_we && bus_addr == A_EVT),
      .msk_we   (bus_we && bus_addr == A_MSK),
      .wdata    (bus_wdata),
      .evt_q    (evt_q[b]),
      .msk_q    (msk_q[b]),
      .req      (bank_req[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < PINS; p++) begin
      if (bus_addr == drv_addr(p)) bus_rdata = {2'b00, drv_q[p]};
      if (bus_addr == sns_addr(p)) bus_rdata = {5'b0, mode_q[p], lvl[p]};
    end
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == EVT_BASE + 8'(b)) bus_rdata = evt_q[b];
      if (bus_addr == MSK_BASE + 8'(b)) bus_rdata = msk_q[b];
    end
  end

  assign irq = |bank_req;

endmodule

// File: tb/edge_gpio_ctrl_test.sv
module edge_gpio_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [15:0] pin_in;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  logic [5:0]  m_drv  [16];
  logic [1:0]  m_mode [16];
  logic [15:0] m_evt;
  logic [15:0] m_msk;
  logic [15:0] m_pins;

  always #5 clk = ~clk;

  edge_gpio_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
  );

  function automatic logic [7:0] a_drv(input int p);
    return (p < 8) ? 8'(8'h2B + p) : 8'(8'h3B + p - 8);
  endfunction

  function automatic logic [7:0] a_sns(input int p);
    return (p < 8) ? 8'(8'h33 + p) : 8'(8'h43 + p - 8);
  endfunction

  function automatic logic exp_oe(input logic [5:0] d);
    return d[5] & ~(d[4] & d[0]);
  endfunction

  function automatic logic exp_edge(input logic [1:0] m, input logic o, input logic n);
    case (m)
      2'd1:    return o & ~n;
      2'd2:    return ~o & n;
      2'd3:    return o ^ n;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk);
    #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [7:0] d;
    logic [15:0] nw;
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
    m_evt = '0; m_msk = '0; m_pins = '0;
    for (int p = 0; p < 16; p++) begin m_drv[p] = '0; m_mode[p] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 oe", pin_oe, 0);
    chk("R1 out", pin_out, 0);
    chk("R1 irq", irq, 0);
    for (int p = 0; p < 16; p++) begin
      rd(a_drv(p), r); chk("R1 drv", r, 0);
      rd(a_sns(p), r); chk("R1 sns", r, 0);
    end
    rd(8'h0B, r); chk("R1 evt0", r, 0);
    rd(8'h0C, r); chk("R1 evt1", r, 0);
    rd(8'h19, r); chk("R1 msk0", r, 0);
    rd(8'h1A, r); chk("R1 msk1", r, 0);

    // R2 R3 R4 random drive writes
    for (int i = 0; i < 60; i++) begin
      int p;
      p = int'($urandom_range(15));
      d = 8'($urandom);
      wr(a_drv(p), d);
      m_drv[p] = d[5:0];
      rd(a_drv(p), r);
      chk("R2 drv readback", r, {2'b00, d[5:0]});
      chk("R3 pin_out", pin_out[p], d[0]);
      chk(d[4] ? "R4 oe open-drain" : "R3 oe push-pull", pin_oe[p], exp_oe(d[5:0]));
    end

    // R4 directed open-drain corners on pin 9
    wr(a_drv(9), 8'h31); @(negedge clk); chk("R4 od high releases", pin_oe[9], 0);
    wr(a_drv(9), 8'h30); @(negedge clk); chk("R4 od low drives", pin_oe[9], 1);
    wr(a_drv(9), 8'h10); @(negedge clk); chk("R4 od input", pin_oe[9], 0);
    wr(a_drv(9), 8'h21); @(negedge clk); chk("R3 push-pull high", pin_oe[9], 1);
    chk("R3 level", pin_out[9], 1);

    // R5 synchronizer latency
    @(negedge clk); pin_in[3] = 1'b1; m_pins[3] = 1'b1;
    @(posedge clk); #1; bus_addr = a_sns(3); @(negedge clk);
    chk("R5 level not after one edge", bus_rdata[0], 0);
    @(posedge clk); @(negedge clk);
    chk("R5 level after two edges", bus_rdata[0], 1);
    repeat (3) @(posedge clk);

    // R11 write to level bit ignored, unmapped reads
    wr(a_sns(4), 8'h01); m_mode[4] = 2'd0;
    rd(a_sns(4), r); chk("R11 level write ignored", r, 0);
    rd(8'h00, r); chk("R11 unmapped 00", r, 0);
    rd(8'h0D, r); chk("R11 unmapped 0D", r, 0);
    rd(8'h1B, r); chk("R11 unmapped 1B", r, 0);
    rd(8'h4B, r); chk("R11 unmapped 4B", r, 0);
    rd(8'hFF, r); chk("R11 unmapped FF", r, 0);

    // R6 R7 R9 R10 random edge rounds
    for (int i = 0; i < 40; i++) begin
      for (int p = 0; p < 16; p++) begin
        d = 8'($urandom);
        wr(a_sns(p), d);
        m_mode[p] = d[2:1];
        rd(a_sns(p), r);
        chk("R5 sense readback", r, {5'b0, d[2:1], m_pins[p]});
      end
      m_msk = 16'($urandom);
      wr(8'h19, m_msk[7:0]);
      wr(8'h1A, m_msk[15:8]);
      rd(8'h19, r); chk("R9 mask0 readback", r, m_msk[7:0]);
      rd(8'h1A, r); chk("R9 mask1 readback", r, m_msk[15:8]);
      wr(8'h0B, 8'hFF);
      wr(8'h0C, 8'hFF);
      m_evt = '0;
      nw = 16'($urandom);
      @(negedge clk);
      pin_in = nw;
      for (int p = 0; p < 16; p++)
        m_evt[p] = exp_edge(m_mode[p], m_pins[p], nw[p]);
      m_pins = nw;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10 irq", irq, |(m_evt & ~m_msk));
      rd(8'h0B, r); chk("R6 R9 events bank0", r, m_evt[7:0]);
      rd(8'h0C, r); chk("R6 R9 events bank1", r, m_evt[15:8]);
      rd(a_sns(i % 16), r); chk("R5 level", r[0], m_pins[i % 16]);
      d = 8'($urandom);
      wr(8'h0B, d);
      m_evt[7:0] = m_evt[7:0] & ~d;
      rd(8'h0B, r); chk("R7 partial clear", r, m_evt[7:0]);
      rd(8'h0C, r); chk("R7 other bank untouched", r, m_evt[15:8]);
      @(negedge clk);
      chk("R10 irq after clear", irq, |(m_evt & ~m_msk));
    end

    // R8 edge coinciding with clear
    wr(a_sns(0), 8'h06);
    wr(8'h19, 8'h00);
    wr(8'h0B, 8'hFF);
    wr(8'h0C, 8'hFF);
    @(negedge clk); pin_in[0] = ~pin_in[0];
    @(negedge clk); pin_in[0] = ~pin_in[0];
    @(posedge clk);
    wr(8'h0B, 8'h01);
    rd(8'h0B, r); chk("R8 edge beats clear", r[0], 1);
    wr(8'h0B, 8'h01);
    rd(8'h0B, r); chk("R7 clear after quiet", r[0], 0);

    // R9 masked event still latched, irq stays low
    wr(8'h1A, 8'hFF);
    wr(8'h19, 8'hFF);
    wr(a_sns(12), 8'h06);
    @(negedge clk); pin_in[12] = ~pin_in[12];
    repeat (3) @(posedge clk);
    rd(8'h0C, r); chk("R9 masked latched", r[4], 1);
    chk("R10 masked no irq", irq, 0);
    wr(8'h1A, 8'h00);
    @(negedge clk); chk("R10 unmask raises irq", irq, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule